// File: doc/BRIEF.md
# Address Register Effective Address Unit

This unit forms the memory address for the register-indirect addressing modes of a 32-bit processor with a 24-bit external address. It holds the address-register file: seven general address registers plus two stack-pointer copies, one for user state and one for supervisor state. For each request it computes the effective address combinationally and, for the auto-increment and auto-decrement modes, writes the stepped register value back on the next rising clock edge.

The caller presents a mode, a register number, an operand size, a 16-bit displacement word and an absolute address. The unit returns the full 32-bit effective address and its low 24 bits for the bus. A separate load port lets the execution stage write a register directly. Loading takes priority over the addressing write-back when both occur in the same cycle.

Top module: `areg_ea_unit`

## Requirements
- R1: An active-low asynchronous reset clears all nine physical registers, both stack-pointer copies included, to zero.
- R2: Mode 0 (plain indirect) returns the selected register as the effective address and leaves the register unchanged.
- R3: Mode 1 (post-increment) returns the old register value as the address and writes back the value plus the step.
- R4: Mode 2 (pre-decrement) writes back the value minus the step and returns that decremented value as the address.
- R5: The step depends on the size code: 1 for byte (0), 2 for word (1) and 4 for long (2). The reserved size code 3 also steps by 4.
- R6: A byte step on register 7, the stack pointer, is 2 instead of 1, so the stack stays word-aligned.
- R7: Mode 3 adds the 16-bit displacement, sign-extended to 32 bits, to the register. The register is not changed.
- R8: Mode 4 passes the 32-bit absolute input through as the effective address without any write-back. Modes 5 to 7 behave as plain indirect.
- R9: `addr_o` carries the low 24 bits of the 32-bit effective address. Arithmetic wraps modulo 2^32.
- R10: Register 7 maps to the supervisor stack copy when `super_i` is 1 and to the user copy when it is 0. Registers 0 to 6 are shared by both states.
- R11: `load_i` writes `load_data_i` into the selected register at the next edge. This takes priority over a simultaneous addressing write-back, and `wb_o` stays 0 during the load.
- R12: A write-back completes in one clock cycle: a read of the same register in the next cycle returns the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ea_req_i | input | 1 | Addressing request; enables write-back |
| mode_i | input | 3 | Addressing mode code |
| reg_sel_i | input | 3 | Address register number |
| size_i | input | 2 | Operand size code |
| disp_i | input | 16 | Signed displacement word |
| abs_i | input | 32 | Absolute address for mode 4 |
| super_i | input | 1 | Supervisor state; selects stack copy |
| load_i | input | 1 | Direct register load |
| load_data_i | input | 32 | Load value |
| ea_o | output | 32 | Full effective address |
| addr_o | output | 24 | Bus address (low 24 bits) |
| wb_o | output | 1 | Addressing write-back occurs this cycle |
| wb_data_o | output | 32 | Stepped register value |

## Verification
The checker examines every request cycle for the address relations of each mode. In post-increment mode the address must equal the unmodified register. In pre-decrement mode the address must equal the value written back. The step must be one of 1, 2 or 4, and a byte step on the stack pointer must be 2. The displacement must be sign-extended, the bus address must be the low 24 bits of the effective address, and no write-back may occur outside the stepping modes. Some behaviours can only be shown by the bench's scenarios, because they span several cycles and need known register contents. These are the reset contents, the committed register value in the cycle after a write-back, the independence of the two stack copies, the priority of a load over a write-back, and wrap-around below zero.

// File: rtl/areg_ea_pkg.sv
package areg_ea_pkg;
  typedef enum logic [2:0] {
    EA_IND     = 3'd0,
    EA_POSTINC = 3'd1,
    EA_PREDEC  = 3'd2,
    EA_DISP    = 3'd3,
    EA_ABS     = 3'd4
  } ea_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } ea_size_e;
endpackage

// File: rtl/areg_file.sv
module areg_file #(
  parameter int DW   = 32,
  parameter int NPHY = 9,
  localparam int PW  = $clog2(NPHY)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] rd_sel_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] regs_q [NPHY];

  for (genvar g = 0; g < NPHY; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == PW'(g))        regs_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NPHY; i++)
      if (rd_sel_i == PW'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/ea_step.sv
module ea_step
  import areg_ea_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    size_i,
  input  logic          is_sp_i,
  output logic [DW-1:0] step_o
);
  always_comb begin
    unique case (ea_size_e'(size_i))
      SZ_BYTE: step_o = is_sp_i ? DW'(2) : DW'(1); // keep stack word-aligned
      SZ_WORD: step_o = DW'(2);
      default: step_o = DW'(4);
    endcase
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import areg_ea_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DISP_W = 16
) (
  input  logic [2:0]        mode_i,
  input  logic [DW-1:0]     base_i,
  input  logic [DW-1:0]     step_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DW-1:0]     abs_i,
  output logic [DW-1:0]     ea_o,
  output logic [DW-1:0]     new_o,
  output logic              upd_o
);
  logic [DW-1:0] disp_ext;
  assign disp_ext = {{(DW-DISP_W){disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    new_o = base_i;
    upd_o = 1'b0;
    ea_o  = base_i;
    case (ea_mode_e'(mode_i))
      EA_POSTINC: begin
        new_o = base_i + step_i;
        upd_o = 1'b1;
      end
      EA_PREDEC: begin
        new_o = base_i - step_i;
        ea_o  = base_i - step_i;
        upd_o = 1'b1;
      end
      EA_DISP:  ea_o = base_i + disp_ext;
      EA_ABS:   ea_o = abs_i;
      default:  ea_o = base_i;
    endcase
  end
endmodule

// File: rtl/areg_ea_unit.sv
module areg_ea_unit #(
  parameter int DW     = 32,
  parameter int BUS_W  = 24,
  parameter int NREG   = 8,
  parameter int DISP_W = 16,
  localparam int RW    = $clog2(NREG),
  localparam int NPHY  = NREG + 1,
  localparam int PW    = $clog2(NPHY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ea_req_i,
  input  logic [2:0]        mode_i,
  input  logic [RW-1:0]     reg_sel_i,
  input  logic [1:0]        size_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DW-1:0]     abs_i,
  input  logic              super_i,
  input  logic              load_i,
  input  logic [DW-1:0]     load_data_i,
  output logic [DW-1:0]     ea_o,
  output logic [BUS_W-1:0]  addr_o,
  output logic              wb_o,
  output logic [DW-1:0]     wb_data_o
);
  logic          is_sp;
  logic [PW-1:0] phys_sel;
  logic [DW-1:0] base_q;
  logic [DW-1:0] step;
  logic [DW-1:0] new_val;
  logic          upd;
  logic          wr_en;
  logic [DW-1:0] wr_data;

  assign is_sp    = (reg_sel_i == RW'(NREG - 1));
  // supervisor stack copy lives in the extra physical slot
  assign phys_sel = (is_sp && super_i) ? PW'(NREG) : PW'(reg_sel_i);

  areg_file #(.DW(DW), .NPHY(NPHY)) u_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_sel_i  (phys_sel),
    .wr_en_i   (wr_en),
    .wr_sel_i  (phys_sel),
    .wr_data_i (wr_data),
    .rd_data_o (base_q)
  );

  ea_step #(.DW(DW)) u_step (
    .size_i  (size_i),
    .is_sp_i (is_sp),
    .step_o  (step)
  );

  ea_calc #(.DW(DW), .DISP_W(DISP_W)) u_calc (
    .mode_i (mode_i),
    .base_i (base_q),
    .step_i (step),
    .disp_i (disp_i),
    .abs_i  (abs_i),
    .ea_o   (ea_o),
    .new_o  (new_val),
    .upd_o  (upd)
  );

  assign wb_o      = ea_req_i && upd && !load_i;
  assign wr_en     = load_i || wb_o;
  assign wr_data   = load_i ? load_data_i : new_val;
  assign wb_data_o = new_val;
  assign addr_o    = ea_o[BUS_W-1:0];
endmodule

// File: rtl/areg_ea_unit_chk.sv
module areg_ea_unit_chk #(
  parameter int DW     = 32,
  parameter int BUS_W  = 24,
  parameter int RW     = 3,
  parameter int DISP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ea_req_i,
  input logic [2:0]        mode_i,
  input logic [RW-1:0]     reg_sel_i,
  input logic [1:0]        size_i,
  input logic [DISP_W-1:0] disp_i,
  input logic              load_i,
  input logic [DW-1:0]     base_q,
  input logic [DW-1:0]     ea_o,
  input logic [BUS_W-1:0]  addr_o,
  input logic              wb_o,
  input logic [DW-1:0]     wb_data_o
);
  logic act;
  assign act = ea_req_i && !load_i;

  p_postinc_old_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && mode_i == 3'd1 |-> ea_o == base_q && wb_o);

  p_predec_new_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && mode_i == 3'd2 |-> ea_o == wb_data_o && wb_o);

  p_step_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && mode_i == 3'd1 |->
      ((wb_data_o - ea_o) == DW'(1) || (wb_data_o - ea_o) == DW'(2) ||
       (wb_data_o - ea_o) == DW'(4)));

  p_sp_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && mode_i == 3'd1 && reg_sel_i == '1 && size_i == 2'd0 |->
      (wb_data_o - ea_o) == DW'(2));

  p_disp_sext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 3'd3 |-> (ea_o - base_q) == {{(DW-DISP_W){disp_i[DISP_W-1]}}, disp_i});

  p_no_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_i == 3'd1 || mode_i == 3'd2) || !ea_req_i |-> !wb_o);

  p_bus_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o == ea_o[BUS_W-1:0]);

  p_load_prio_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !wb_o);
endmodule

bind areg_ea_unit areg_ea_unit_chk #(
  .DW(DW), .BUS_W(BUS_W), .RW(RW), .DISP_W(DISP_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ea_req_i  (ea_req_i),
  .mode_i    (mode_i),
  .reg_sel_i (reg_sel_i),
  .size_i    (size_i),
  .disp_i    (disp_i),
  .load_i    (load_i),
  .base_q    (base_q),
  .ea_o      (ea_o),
  .addr_o    (addr_o),
  .wb_o      (wb_o),
  .wb_data_o (wb_data_o)
);

// File: tb/areg_ea_unit_test.sv
module areg_ea_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ea_req_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [2:0]  reg_sel_i = '0;
  logic [1:0]  size_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] abs_i = '0;
  logic        super_i = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] load_data_i = '0;
  logic [31:0] ea_o;
  logic [23:0] addr_o;
  logic        wb_o;
  logic [31:0] wb_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  areg_ea_unit uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic req, input logic [2:0] m, input logic [2:0] r,
                        input logic [1:0] sz, input logic [15:0] d, input logic [31:0] a,
                        input logic sup, input logic ld, input logic [31:0] ldv);
    @(negedge clk_i);
    ea_req_i = req; mode_i = m; reg_sel_i = r; size_i = sz; disp_i = d;
    abs_i = a; super_i = sup; load_i = ld; load_data_i = ldv;
    #1;
  endtask

  task automatic tick;
    @(posedge clk_i);
    #1;
  endtask

  task automatic load_reg(input logic [2:0] r, input logic sup, input logic [31:0] v);
    set_in(1'b0, 3'd0, r, 2'd0, 16'h0, 32'h0, sup, 1'b1, v);
    tick();
  endtask

  task automatic read_reg(input logic [2:0] r, input logic sup, output logic [31:0] v);
    set_in(1'b0, 3'd0, r, 2'd0, 16'h0, 32'h0, sup, 1'b0, 32'h0);
    v = ea_o;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int r = 0; r < 8; r++) begin
      read_reg(3'(r), 1'b0, v);
      chk("R1 reset user reg", v, 32'h0);
    end
    read_reg(3'd7, 1'b1, v);
    chk("R1 reset super sp", v, 32'h0);
  endtask

  task automatic t_plain;
    logic [31:0] v;
    load_reg(3'd2, 1'b0, 32'h0012_3456);
    set_in(1'b1, 3'd0, 3'd2, 2'd2, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R2 plain addr", ea_o, 32'h0012_3456);
    chk("R2 plain no wb", 32'(wb_o), 32'h0);
    tick();
    read_reg(3'd2, 1'b0, v);
    chk("R2 plain reg unchanged", v, 32'h0012_3456);
    set_in(1'b1, 3'd6, 3'd2, 2'd1, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R8 mode 6 as plain", ea_o, 32'h0012_3456);
    chk("R8 mode 6 no wb", 32'(wb_o), 32'h0);
    tick();
  endtask

  task automatic t_postinc;
    logic [31:0] v;
    load_reg(3'd3, 1'b0, 32'h0000_1000);
    set_in(1'b1, 3'd1, 3'd3, 2'd1, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R3 postinc old addr", ea_o, 32'h0000_1000);
    chk("R3 postinc wb", 32'(wb_o), 32'h1);
    tick();
    read_reg(3'd3, 1'b0, v);
    chk("R12 R5 word step committed", v, 32'h0000_1002);
    set_in(1'b1, 3'd1, 3'd3, 2'd0, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    tick();
    read_reg(3'd3, 1'b0, v);
    chk("R5 byte step", v, 32'h0000_1003);
    set_in(1'b1, 3'd1, 3'd3, 2'd2, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    tick();
    read_reg(3'd3, 1'b0, v);
    chk("R5 long step", v, 32'h0000_1007);
    set_in(1'b1, 3'd1, 3'd3, 2'd3, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    tick();
    read_reg(3'd3, 1'b0, v);
    chk("R5 reserved size step 4", v, 32'h0000_100B);
  endtask

  task automatic t_predec;
    logic [31:0] v;
    load_reg(3'd4, 1'b0, 32'h0000_2000);
    set_in(1'b1, 3'd2, 3'd4, 2'd2, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R4 predec new addr", ea_o, 32'h0000_1FFC);
    tick();
    read_reg(3'd4, 1'b0, v);
    chk("R4 predec committed", v, 32'h0000_1FFC);
    set_in(1'b1, 3'd2, 3'd4, 2'd0, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R4 R5 predec byte addr", ea_o, 32'h0000_1FFB);
    tick();
    load_reg(3'd1, 1'b0, 32'h0);
    set_in(1'b1, 3'd2, 3'd1, 2'd1, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R9 wrap ea", ea_o, 32'hFFFF_FFFE);
    chk("R9 wrap bus", 32'(addr_o), 32'h00FF_FFFE);
    tick();
  endtask

  task automatic t_sp;
    logic [31:0] v;
    load_reg(3'd7, 1'b0, 32'h0000_3000);
    set_in(1'b1, 3'd1, 3'd7, 2'd0, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    tick();
    read_reg(3'd7, 1'b0, v);
    chk("R6 sp byte postinc 2", v, 32'h0000_3002);
    set_in(1'b1, 3'd2, 3'd7, 2'd0, 16'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R6 sp byte predec 2", ea_o, 32'h0000_3000);
    tick();
    load_reg(3'd7, 1'b1, 32'h0000_8000);
    read_reg(3'd7, 1'b0, v);
    chk("R10 user sp untouched", v, 32'h0000_3000);
    read_reg(3'd7, 1'b1, v);
    chk("R10 super sp", v, 32'h0000_8000);
    set_in(1'b1, 3'd2, 3'd7, 2'd1, 16'h0, 32'h0, 1'b1, 1'b0, 32'h0);
    tick();
    read_reg(3'd7, 1'b0, v);
    chk("R10 user sp after super predec", v, 32'h0000_3000);
    read_reg(3'd7, 1'b1, v);
    chk("R10 super sp predec", v, 32'h0000_7FFE);
    load_reg(3'd0, 1'b1, 32'h0000_4444);
    read_reg(3'd0, 1'b0, v);
    chk("R10 shared reg", v, 32'h0000_4444);
  endtask

  task automatic t_disp;
    logic [31:0] v;
    load_reg(3'd5, 1'b0, 32'h0001_0000);
    set_in(1'b1, 3'd3, 3'd5, 2'd1, 16'hFFFE, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R7 negative disp", ea_o, 32'h0000_FFFE);
    chk("R7 disp no wb", 32'(wb_o), 32'h0);
    tick();
    set_in(1'b1, 3'd3, 3'd5, 2'd1, 16'h0100, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R7 positive disp", ea_o, 32'h0001_0100);
    tick();
    read_reg(3'd5, 1'b0, v);
    chk("R7 reg unchanged", v, 32'h0001_0000);
  endtask

  task automatic t_abs_bus;
    logic [31:0] v;
    set_in(1'b1, 3'd4, 3'd5, 2'd2, 16'h0, 32'hABCD_EF12, 1'b0, 1'b0, 32'h0);
    chk("R8 abs ea", ea_o, 32'hABCD_EF12);
    chk("R9 abs bus", 32'(addr_o), 32'h00CD_EF12);
    chk("R8 abs no wb", 32'(wb_o), 32'h0);
    tick();
    read_reg(3'd5, 1'b0, v);
    chk("R8 abs reg unchanged", v, 32'h0001_0000);
    load_reg(3'd6, 1'b0, 32'hFF12_3456);
    read_reg(3'd6, 1'b0, v);
    chk("R9 bus low bits", 32'(addr_o), 32'h0012_3456);
  endtask

  task automatic t_load_prio;
    logic [31:0] v;
    set_in(1'b1, 3'd1, 3'd3, 2'd2, 16'h0, 32'h0, 1'b0, 1'b1, 32'h0000_5000);
    chk("R11 no wb during load", 32'(wb_o), 32'h0);
    tick();
    read_reg(3'd3, 1'b0, v);
    chk("R11 load wins", v, 32'h0000_5000);
  endtask

  task automatic t_reset_again;
    logic [31:0] v;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    rst_ni = 1'b1;
    read_reg(3'd3, 1'b0, v);
    chk("R1 async reset clears", v, 32'h0);
    read_reg(3'd7, 1'b1, v);
    chk("R1 async reset super sp", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_plain();
    t_postinc();
    t_predec();
    t_sp();
    t_disp();
    t_abs_bus();
    t_load_prio();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule